// File: doc/BRIEF.md
# Register-Based Page Translation Unit

This block maps a 16-bit logical address onto a physical address through a page table of eight entries. The table is held in dedicated flip-flops. The top three address bits pick an entry. The remaining 13 bits are a byte offset inside an 8 KB page, and they pass straight through to the physical address. Each entry holds a frame number, a valid flag and three permission flags: read, write and execute. Any mix of the three may be granted.

Translation is combinational. In the same cycle that the physical address is formed, the unit checks the access against the entry's valid flag and permission flags. A failed check raises a fault with a two-bit code and suppresses the memory enable. The table is loaded through a write port that honours a privilege input. An attempt to write the table without privilege changes nothing and raises its own fault code.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset every entry is invalid, so any lookup issued before a table write returns fault code 1.
- R2: The page index is `la_i[15:13]`. The physical address `pa_o` is `{frame, la_i[12:0]}`, so `pa_o` is FRAME_W+13 bits wide.
- R3: A privileged table write (`tw_en_i=1`, `priv_i=1`) updates entry `tw_idx_i` at the clock edge. A lookup in the same cycle still sees the old contents, and later lookups see the new contents.
- R4: A table write with `priv_i=0` leaves the table unchanged.
- R5: A table write with `priv_i=0` raises fault code 3 in that cycle. Code 3 wins over any lookup fault in the same cycle.
- R6: A lookup (`req_i=1`) of an entry whose valid flag is clear gives fault code 1.
- R7: Permission flags are bit 0 read, bit 1 write and bit 2 execute. The access type `acc_i` is 0 for read, 1 for write, 2 for execute and 3 for reserved. A valid entry whose flag for the access is clear gives fault code 2, and access type 3 always gives code 2.
- R8: Fault code 1 takes priority over code 2, and code 0 means no fault. `fault_o` is high exactly when the code is not 0.
- R9: While `fault_o` is high, `pa_o` is zero and `mem_en_o` is low.
- R10: `mem_en_o` is high exactly when `req_i` is high and there is no fault. When `mem_en_o` is low, `pa_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup request |
| la_i | input | 16 | Logical address |
| acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| priv_i | input | 1 | Privileged mode |
| tw_en_i | input | 1 | Table write strobe |
| tw_idx_i | input | 3 | Entry to write |
| tw_frame_i | input | 6 | Frame number to store |
| tw_valid_i | input | 1 | Valid flag to store |
| tw_perm_i | input | 3 | Permission flags to store (bit 0 read, bit 1 write, bit 2 execute) |
| pa_o | output | 19 | Physical address |
| mem_en_o | output | 1 | Memory enable for a clean translation |
| fault_o | output | 1 | Fault present |
| fault_code_o | output | 2 | 0 none, 1 invalid page, 2 protection, 3 privilege |

## Verification
A table write and a lookup can fall in the same cycle, including a lookup of the very entry being written. The bench provokes this by issuing a lookup of the target page with every write, both privileged and unprivileged. After a privileged write, the result must reflect the old entry in that cycle and the new entry from the next cycle on. After an unprivileged write, the result must be fault code 3 in that cycle, and later lookups must show that the table is unchanged. Every permission mix, both valid states, every page and every access type are swept, and the expected results are computed arithmetically in the bench.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_INVAL = 2'd1,
    FLT_PROT  = 2'd2,
    FLT_PRIV  = 2'd3
  } fault_e;

  localparam int unsigned PERM_W = 3;

  // permission bit for an access type; reserved type never granted
  function automatic logic perm_grant(logic [PERM_W-1:0] perm, logic [1:0] acc);
    logic g;
    case (acc)
      ACC_RD:  g = perm[0];
      ACC_WR:  g = perm[1];
      ACC_EX:  g = perm[2];
      default: g = 1'b0;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/ptu_table.sv
module ptu_table import ptu_pkg::*; #(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned FRAME_W = 6,
  localparam int unsigned N_ENT  = 1 << IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               priv_i,
  input  logic [IDX_W-1:0]   widx_i,
  input  logic [FRAME_W-1:0] wframe_i,
  input  logic               wvalid_i,
  input  logic [PERM_W-1:0]  wperm_i,
  input  logic [IDX_W-1:0]   ridx_i,
  output logic [FRAME_W-1:0] rframe_o,
  output logic               rvalid_o,
  output logic [PERM_W-1:0]  rperm_o
);
  logic [FRAME_W-1:0] frame_q [N_ENT];
  logic               valid_q [N_ENT];
  logic [PERM_W-1:0]  perm_q  [N_ENT];
  logic               we_ok;

  // privilege gate: unprivileged updates dropped
  assign we_ok = we_i & priv_i;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        frame_q[g] <= '0;
        valid_q[g] <= 1'b0;
        perm_q[g]  <= '0;
      end else if (we_ok && (widx_i == IDX_W'(g))) begin
        frame_q[g] <= wframe_i;
        valid_q[g] <= wvalid_i;
        perm_q[g]  <= wperm_i;
      end
    end
  end

  assign rframe_o = frame_q[ridx_i];
  assign rvalid_o = valid_q[ridx_i];
  assign rperm_o  = perm_q[ridx_i];
endmodule

// File: rtl/ptu_check.sv
module ptu_check import ptu_pkg::*; (
  input  logic              req_i,
  input  logic [1:0]        acc_i,
  input  logic              valid_i,
  input  logic [PERM_W-1:0] perm_i,
  output fault_e            code_o
);
  always_comb begin
    code_o = FLT_NONE;
    if (req_i) begin
      if (!valid_i)                        code_o = FLT_INVAL;
      else if (!perm_grant(perm_i, acc_i)) code_o = FLT_PROT;
    end
  end
endmodule

// File: rtl/ptu_resolve.sv
module ptu_resolve import ptu_pkg::*; #(
  parameter int unsigned FRAME_W = 6,
  parameter int unsigned OFF_W   = 13,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input  logic               req_i,
  input  logic               priv_flt_i,
  input  fault_e             lk_code_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [OFF_W-1:0]   off_i,
  output logic [PA_W-1:0]    pa_o,
  output logic               mem_en_o,
  output logic               fault_o,
  output logic [1:0]         code_o
);
  fault_e code;

  always_comb begin
    code = priv_flt_i ? FLT_PRIV : lk_code_i;
    fault_o  = (code != FLT_NONE);
    mem_en_o = req_i & ~fault_o;
    pa_o     = mem_en_o ? {frame_i, off_i} : '0;
    code_o   = code;
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit import ptu_pkg::*; #(
  parameter int unsigned LA_W    = 16,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned FRAME_W = 6,
  localparam int unsigned OFF_W  = LA_W - IDX_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [LA_W-1:0]    la_i,
  input  logic [1:0]         acc_i,
  input  logic               priv_i,
  input  logic               tw_en_i,
  input  logic [IDX_W-1:0]   tw_idx_i,
  input  logic [FRAME_W-1:0] tw_frame_i,
  input  logic               tw_valid_i,
  input  logic [2:0]         tw_perm_i,
  output logic [PA_W-1:0]    pa_o,
  output logic               mem_en_o,
  output logic               fault_o,
  output logic [1:0]         fault_code_o
);
  logic [IDX_W-1:0]   page;
  logic [OFF_W-1:0]   off;
  logic [FRAME_W-1:0] e_frame;
  logic               e_valid;
  logic [PERM_W-1:0]  e_perm;
  fault_e             lk_code;
  logic               priv_flt;

  assign page     = la_i[LA_W-1:OFF_W];
  assign off      = la_i[OFF_W-1:0];
  assign priv_flt = tw_en_i & ~priv_i;

  ptu_table #(.IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tw_en_i),
    .priv_i  (priv_i),
    .widx_i  (tw_idx_i),
    .wframe_i(tw_frame_i),
    .wvalid_i(tw_valid_i),
    .wperm_i (tw_perm_i),
    .ridx_i  (page),
    .rframe_o(e_frame),
    .rvalid_o(e_valid),
    .rperm_o (e_perm)
  );

  ptu_check u_check (
    .req_i  (req_i),
    .acc_i  (acc_i),
    .valid_i(e_valid),
    .perm_i (e_perm),
    .code_o (lk_code)
  );

  ptu_resolve #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) u_resolve (
    .req_i     (req_i),
    .priv_flt_i(priv_flt),
    .lk_code_i (lk_code),
    .frame_i   (e_frame),
    .off_i     (off),
    .pa_o      (pa_o),
    .mem_en_o  (mem_en_o),
    .fault_o   (fault_o),
    .code_o    (fault_code_o)
  );
endmodule

// File: rtl/page_xlate_unit_chk.sv
module page_xlate_unit_chk #(
  parameter int unsigned LA_W    = 16,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned FRAME_W = 6,
  localparam int unsigned OFF_W  = LA_W - IDX_W,
  localparam int unsigned PA_W   = FRAME_W + OFF_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [LA_W-1:0] la_i,
  input logic            priv_i,
  input logic            tw_en_i,
  input logic [PA_W-1:0] pa_o,
  input logic            mem_en_o,
  input logic            fault_o,
  input logic [1:0]      fault_code_o
);
  // R9
  fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (pa_o == '0 && !mem_en_o));

  // R5
  priv_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tw_en_i && !priv_i) |-> (fault_code_o == 2'd3));

  // R8
  fault_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o == (fault_code_o != 2'd0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i) |-> (!mem_en_o && pa_o == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> (pa_o[OFF_W-1:0] == la_i[OFF_W-1:0]));
endmodule

bind page_xlate_unit page_xlate_unit_chk #(
  .LA_W(LA_W), .IDX_W(IDX_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .la_i        (la_i),
  .priv_i      (priv_i),
  .tw_en_i     (tw_en_i),
  .pa_o        (pa_o),
  .mem_en_o    (mem_en_o),
  .fault_o     (fault_o),
  .fault_code_o(fault_code_o)
);

// File: tb/page_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module page_xlate_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] la_i = '0;
  logic [1:0]  acc_i = '0;
  logic        priv_i = 1'b0;
  logic        tw_en_i = 1'b0;
  logic [2:0]  tw_idx_i = '0;
  logic [5:0]  tw_frame_i = '0;
  logic        tw_valid_i = 1'b0;
  logic [2:0]  tw_perm_i = '0;
  logic [18:0] pa_o;
  logic        mem_en_o, fault_o;
  logic [1:0]  fault_code_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model of the table
  logic [5:0] m_frame [8];
  logic       m_valid [8];
  logic [2:0] m_perm  [8];

  always #2.5 clk_i = ~clk_i;

  page_xlate_unit dut_i (.*);

  task automatic check(input string req);
    logic [2:0]  pg;
    logic [1:0]  ec;
    logic        em;
    logic [18:0] ep;
    pg = la_i[15:13];
    if (tw_en_i && !priv_i) ec = 2'd3;
    else if (!req_i) ec = 2'd0;
    else if (!m_valid[pg]) ec = 2'd1;
    else if (acc_i == 2'd3 || !m_perm[pg][acc_i]) ec = 2'd2;
    else ec = 2'd0;
    em = req_i && (ec == 2'd0);
    ep = em ? {m_frame[pg], la_i[12:0]} : 19'd0;
    n_chk++;
    if (fault_code_o !== ec || mem_en_o !== em || pa_o !== ep || fault_o !== (ec != 0)) begin
      n_bad++;
      $display("FAIL %s: code=%0d en=%0b pa=%h flt=%0b expected code=%0d en=%0b pa=%h",
               req, fault_code_o, mem_en_o, pa_o, fault_o, ec, em, ep);
    end
  endtask

  // one cycle: drive after negedge, check, let the posedge commit
  task automatic step(input bit rq, input logic [15:0] la, input logic [1:0] acc,
                      input bit pv, input bit we, input logic [2:0] idx,
                      input logic [5:0] fr, input bit v, input logic [2:0] pm,
                      input string req);
    @(negedge clk_i);
    req_i = rq; la_i = la; acc_i = acc; priv_i = pv; tw_en_i = we;
    tw_idx_i = idx; tw_frame_i = fr; tw_valid_i = v; tw_perm_i = pm;
    #1;
    check(req);
    if (we && pv) begin
      m_frame[idx] = fr; m_valid[idx] = v; m_perm[idx] = pm;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_frame[i] = '0; m_valid[i] = 1'b0; m_perm[i] = '0;
    end
    #7 rst_ni = 1'b1;
    // R1: reset state, every page invalid
    for (int p = 0; p < 8; p++)
      step(1, {p[2:0], 13'h0AB}, 2'd0, 1, 0, 0, 0, 0, 0, "R1");
    step(0, 16'h0, 2'd0, 0, 0, 0, 0, 0, 0, "R10");
    for (int pm = 0; pm < 8; pm++)
      for (int v = 0; v < 2; v++)
        for (int p = 0; p < 8; p++) begin
          logic [5:0] fr;
          fr = 6'((p * 5 + pm * 3 + v * 17) & 63);
          // R3: same-cycle lookup sees old entry
          step(1, {p[2:0], 13'h1234}, 2'd0, 1, 1, p[2:0], fr, v[0], pm[2:0], "R3");
          for (int a = 0; a < 4; a++) begin
            step(1, {p[2:0], 13'h0000}, a[1:0], a[0], 0, 0, 0, 0, 0, "R7");
            step(1, {p[2:0], 13'h1FFF}, a[1:0], 0, 0, 0, 0, 0, 0, "R2");
          end
          // R5: unprivileged write with lookup in same cycle
          step(1, {p[2:0], 13'h0555}, 2'd1, 0, 1, p[2:0], ~fr, ~v[0], ~pm[2:0], "R5");
          // R4: table unchanged afterwards
          step(1, {p[2:0], 13'h0AAA}, 2'd0, 0, 0, 0, 0, 0, 0, "R4");
          step(1, {p[2:0], 13'h0AAA}, 2'd2, 1, 0, 0, 0, 0, 0, "R6");
          step(0, {p[2:0], 13'h0AAA}, 2'd2, 1, 0, 0, 0, 0, 0, "R10");
        end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule